// File: doc/BRIEF.md
# Serial OSD Packet Decoder

This block sits between a serial host link and the character memory of an on-screen display. A host lowers a select line, clocks bytes in most significant bit first, and raises select when the packet is done. The block assembles each byte, reads its two top bits as a tag, and turns the stream into single-cycle memory write strobes. Each strobe carries a row, a column and a data byte.

Three addressing formats share one packet grammar. In the scattered format, every data byte comes with its own row and column. In the row-local format, only a new column comes before each data byte. In the burst format, one starting address is followed by any number of data bytes, and the column steps by itself. The serial inputs are taken into the system clock domain through synchronisers. All sizes are parameters.

Top module: `osd_packet_decoder`

## Requirements
- R1: With select low, eight rising serial-clock edges shift in one byte, MSB first. A byte completes only while select is low.
- R2: A byte with bit 7 = 1 is a row address, taken from bits 3..0. It never produces a write by itself.
- R3: Scattered format: after a row byte, a byte with bits 7..6 = 00 sets the column from bits 4..0. The next byte, whatever its value, is written at that row and column. After that data byte, a new row byte is accepted.
- R4: Row-local format: after a data byte in the scattered or row-local format, a byte with bits 7..6 = 00 sets a new column in the same row, and the next byte is written there.
- R5: Burst format: a column byte with bits 7..6 = 01 enters burst mode. This can follow a row byte or a data byte of the other formats. Every later byte in the packet is data, including bytes with bit 7 = 1. The column increments after each write.
- R6: In burst mode the column runs through 24..31 like any other value. From 31 it wraps to 0 and the row increments.
- R7: In burst mode the row stops incrementing at 10 (the top of the map); only the column keeps wrapping.
- R8: Raising select returns the decoder to its initial state and drops any partly shifted byte.
- R9: A byte whose tag does not fit the current state is dropped with no write. This covers a column or data byte before any row byte, and a second row byte right after a row byte.
- R10: After reset, the write strobe is low and the row, column and data outputs are zero.
- R11: Each accepted data byte gives exactly one write strobe, one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Packet select, active low, asynchronous to clk |
| sclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The bench runs packets in each format. A scattered packet and a row-local packet show whether the row is kept or replaced. A switch from row-local to burst mid-packet and a burst that runs past column 31 show whether the address steps and whether bytes with bit 7 set are taken as data. A burst starting in row 10 separates saturation from wrap. Packets that start with stray bytes, repeat a row byte, or are cut off by select part-way through a byte show whether out-of-place input is dropped and whether byte alignment recovers. A misplaced, missing or extra write shows up as a scoreboard mismatch.

// File: rtl/osd_pkt_pkg.sv
package osd_pkt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TAG_ROW,
    TAG_COL_AB,
    TAG_COL_C
  } tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COLAB,
    ST_COLC,
    ST_DAAB,
    ST_DAC
  } st_e;

  function automatic tag_e byte_tag(input logic [BYTE_W-1:0] b);
    if (b[BYTE_W-1])      return TAG_ROW;
    else if (b[BYTE_W-2]) return TAG_COL_C;
    else                  return TAG_COL_AB;
  endfunction
endpackage

// File: rtl/osd_bit_shifter.sv
module osd_bit_shifter
  import osd_pkt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sel_act,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sel_sync, sclk_sync, sdi_sync;
  logic                   sclk_d;
  logic                   sclk_rise;
  logic                   sdi_s;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]      shreg;

  // synchronisers into clk domain; select idles inactive
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sync  <= '1;
      sclk_sync <= '0;
      sdi_sync  <= '0;
      sclk_d    <= 1'b0;
    end else begin
      sel_sync  <= {sel_sync[SYNC_STAGES-2:0], sel_n};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      sdi_sync  <= {sdi_sync[SYNC_STAGES-2:0], sdi};
      sclk_d    <= sclk_sync[SYNC_STAGES-1];
    end
  end

  assign sel_act   = ~sel_sync[SYNC_STAGES-1];
  assign sdi_s     = sdi_sync[SYNC_STAGES-1];
  assign sclk_rise = sclk_sync[SYNC_STAGES-1] & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else if (!sel_act) begin
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (sclk_rise) begin
        shreg   <= {shreg[BYTE_W-2:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_q   <= {shreg[BYTE_W-2:0], sdi_s};
          byte_vld <= 1'b1;
        end
      end
    end
  end

  // R1: a byte only completes while select was active
  assert_byte_in_sel_R1: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(sel_act));

  // R8: a partial byte is dropped when select is released
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> (bit_cnt == '0 && !byte_vld));
endmodule

// File: rtl/osd_addr_ctr.sv
module osd_addr_ctr #(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 5,
  parameter int ROW_TOP = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_row,
  input  logic [ROW_W-1:0] row_in,
  input  logic             load_col,
  input  logic [COL_W-1:0] col_in,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] COL_MAX = '1;
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(ROW_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
    end else begin
      if (load_row) row <= row_in;
      if (load_col) col <= col_in;
      if (step && !load_row && !load_col) begin
        if (col == COL_MAX) begin
          col <= '0;
          if (row < ROW_LIM) row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  // R6: stepping past the last column wraps into the next row
  assert_col_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load_row && !load_col && col == COL_MAX && row < ROW_LIM)
      |=> (col == '0 && row == $past(row) + 1'b1));

  // R7: the row holds once it reaches the top of the map
  assert_row_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !load_row && !load_col && row >= ROW_LIM) |=> row == $past(row));
endmodule

// File: rtl/osd_byte_fsm.sv
module osd_byte_fsm
  import osd_pkt_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic              load_row,
  output logic [ROW_W-1:0]  row_in,
  output logic              load_col,
  output logic [COL_W-1:0]  col_in,
  output logic              step,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data
);
  st_e  st, nxt;
  tag_e tag;
  logic wr;

  assign tag    = byte_tag(byte_i);
  assign row_in = byte_i[ROW_W-1:0];
  assign col_in = byte_i[COL_W-1:0];

  always_comb begin
    nxt      = st;
    load_row = 1'b0;
    load_col = 1'b0;
    step     = 1'b0;
    wr       = 1'b0;
    if (byte_vld) begin
      unique case (st)
        ST_IDLE: begin
          if (tag == TAG_ROW) begin
            load_row = 1'b1;
            nxt      = ST_ROW;
          end
        end
        ST_ROW: begin
          if (tag == TAG_COL_AB) begin
            load_col = 1'b1;
            nxt      = ST_COLAB;
          end else if (tag == TAG_COL_C) begin
            load_col = 1'b1;
            nxt      = ST_COLC;
          end
        end
        ST_COLAB: begin
          wr  = 1'b1;
          nxt = ST_DAAB;
        end
        ST_COLC: begin
          wr   = 1'b1;
          step = 1'b1;
          nxt  = ST_DAC;
        end
        ST_DAAB: begin
          if (tag == TAG_ROW) begin
            load_row = 1'b1;
            nxt      = ST_ROW;
          end else if (tag == TAG_COL_AB) begin
            load_col = 1'b1;
            nxt      = ST_COLAB;
          end else begin
            load_col = 1'b1;
            nxt      = ST_COLC;
          end
        end
        ST_DAC: begin
          wr   = 1'b1;
          step = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else begin
      st    <= sel_act ? nxt : ST_IDLE;
      wr_en <= wr;
      if (wr) begin
        wr_row  <= row;
        wr_col  <= col;
        wr_data <= byte_i;
      end
    end
  end

  // R5: burst mode is kept until the packet ends
  assert_burst_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DAC && sel_act) |=> st == ST_DAC);

  // R8: released select puts the decoder back to its start state
  assert_idle_on_release_R8: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> st == ST_IDLE);

  // R11: a strobe follows a completed byte and lasts one cycle
  assert_wr_from_byte_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(byte_vld));
  assert_wr_single_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R2: a row byte taken from idle writes nothing
  assert_row_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && st == ST_IDLE) |=> !wr_en);
endmodule

// File: rtl/osd_packet_decoder.sv
module osd_packet_decoder
  import osd_pkt_pkg::*;
#(
  parameter int ROW_W       = 4,
  parameter int COL_W       = 5,
  parameter int ROW_TOP     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data
);
  logic              sel_act, byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              load_row, load_col, step;
  logic [ROW_W-1:0]  row_in, row;
  logic [COL_W-1:0]  col_in, col;

  osd_bit_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sel_act(sel_act), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  osd_byte_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst(rst), .sel_act(sel_act), .byte_vld(byte_vld),
    .byte_i(byte_q), .row(row), .col(col),
    .load_row(load_row), .row_in(row_in), .load_col(load_col),
    .col_in(col_in), .step(step),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  osd_addr_ctr #(.ROW_W(ROW_W), .COL_W(COL_W), .ROW_TOP(ROW_TOP)) u_addr (
    .clk(clk), .rst(rst), .load_row(load_row), .row_in(row_in),
    .load_col(load_col), .col_in(col_in), .step(step),
    .row(row), .col(col)
  );
endmodule

// File: tb/sim_osd_packet_decoder.sv
module sim_osd_packet_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  typedef struct {
    int    r;
    int    c;
    int    d;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  logic prev_wr  = 1'b0;

  always #2.5 clk = ~clk;

  osd_packet_decoder u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  task automatic expect_wr(input int r, input int c, input int d, input string req);
    exp_t e;
    e.r = r; e.c = c; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic sel_on;
    sel_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_off;
    repeat (8) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en && prev_wr) begin
        n_checks++;
        n_fail++;
        $display("FAIL R11: strobe high two cycles, actual 1 expected 0");
      end
      if (wr_en) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9: unexpected write row=%0d col=%0d data=%02h, expected none",
                   wr_row, wr_col, wr_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (int'(wr_row) != e.r || int'(wr_col) != e.c || int'(wr_data) != e.d) begin
            n_fail++;
            $display("FAIL %s: actual row=%0d col=%0d data=%02h expected row=%0d col=%0d data=%02h",
                     e.req, wr_row, wr_col, wr_data, e.r, e.c, e.d);
          end
        end
      end
      prev_wr = wr_en;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    n_checks++;
    if (wr_en !== 1'b0 || wr_row !== 4'd0 || wr_col !== 5'd0 || wr_data !== 8'd0) begin
      n_fail++;
      $display("FAIL R10: actual en=%0b row=%0d col=%0d data=%02h expected all zero",
               wr_en, wr_row, wr_col, wr_data);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R3 scattered format, R2 row bytes
    sel_on();
    expect_wr(2, 5, 8'h41, "R3");
    send_byte(8'h82); send_byte(8'h05); send_byte(8'h41);
    expect_wr(3, 7, 8'hC2, "R3");
    send_byte(8'h83); send_byte(8'h07); send_byte(8'hC2);
    sel_off();

    // R4 row-local format, back to scattered, then R5 burst from row-local
    sel_on();
    expect_wr(1, 0, 8'h10, "R4");
    send_byte(8'h81); send_byte(8'h00); send_byte(8'h10);
    expect_wr(1, 9, 8'h11, "R4");
    send_byte(8'h09); send_byte(8'h11);
    expect_wr(1, 23, 8'h12, "R4");
    send_byte(8'h17); send_byte(8'h12);
    expect_wr(4, 2, 8'h13, "R3");
    send_byte(8'h84); send_byte(8'h02); send_byte(8'h13);
    expect_wr(4, 6, 8'h14, "R4");
    send_byte(8'h06); send_byte(8'h14);
    expect_wr(4, 2, 8'h90, "R5");
    expect_wr(4, 3, 8'h91, "R5");
    send_byte(8'h42); send_byte(8'h90); send_byte(8'h91);
    sel_off();

    // R5/R6 burst across unused columns and the row wrap
    sel_on();
    send_byte(8'h80); send_byte(8'h54);
    for (int i = 0; i < 14; i++) begin
      int c;
      int r;
      logic [7:0] d;
      c = 20 + i;
      r = 0;
      if (c > 31) begin c = c - 32; r = 1; end
      d = (i == 3) ? 8'h85 : 8'(8'h60 + i);
      expect_wr(r, c, d, (c >= 24 || r == 1) ? "R6" : "R5");
      send_byte(d);
    end
    sel_off();

    // R7 saturation at row 10
    sel_on();
    send_byte(8'h8A); send_byte(8'h5E);
    expect_wr(10, 30, 8'hA0, "R7");
    expect_wr(10, 31, 8'hA1, "R7");
    expect_wr(10, 0,  8'hA2, "R7");
    expect_wr(10, 1,  8'hA3, "R7");
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    sel_off();

    // R9 misplaced bytes dropped
    sel_on();
    send_byte(8'h05); send_byte(8'h33);
    send_byte(8'h86); send_byte(8'h87);
    expect_wr(6, 3, 8'h11, "R9");
    send_byte(8'h03); send_byte(8'h11);
    sel_off();

    // R8 release resets state, R1 partial byte discarded
    sel_on();
    send_byte(8'h85); send_byte(8'h04);
    sel_off();
    sel_on();
    send_byte(8'h22);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    sel_off();
    sel_on();
    expect_wr(8, 1, 8'h33, "R8");
    send_byte(8'h88); send_byte(8'h01); send_byte(8'h33);
    sel_off();

    repeat (20) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: missing writes, actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule